// File: doc/BRIEF.md
# Burst-Capable 12-Bit Pulse-Width Modulator

This block generates a single pulse-width-modulated output whose period and high time are set with 12-bit resolution through a small register port. Once enabled, each period begins with the output high. The output stays high for the programmed duty count and is low for the rest of the period. Period and duty writes go to shadow registers. The counter picks them up only when a run starts or when a period wraps, so a change never produces a truncated or stretched pulse.

Two run modes exist. Continuous mode repeats until software clears the enable bit. Burst mode emits a programmed number of periods, then drops the output, parks the counter and clears the enable bit by itself. The count advances either on every system clock or only on cycles where an auxiliary fast-clock strobe is present, chosen by a control bit. Two sticky event flags are driven as outputs for an interrupt controller. One marks the end of every period and the other marks the completion of a burst.

Top module: `pwm12_burst`

## Requirements
- R1: The period register P sets the period length to P count ticks, with P = 0 treated as 1; the pattern repeats every period while enabled.
- R2: With duty value D, the output is high for the first D ticks of each period (counter value below D) and low for the remaining ticks.
- R3: With CTRL bit 1 set (burst mode), after N completed periods (BURST register N, with 0 treated as 1) the output goes low, the counter holds and CTRL bit 0 reads back 0 without a bus write.
- R4: With CTRL bit 1 clear, the output runs until a CTRL write with bit 0 clear, which stops it at that clock edge with the output low.
- R5: Writes to PERIOD and DUTY take effect only when a run starts or at the next period boundary; the period in progress completes with the old values.
- R6: A duty value of 0 gives a constantly low output; a duty value greater than or equal to the period gives a constantly high output.
- R7: CTRL bit 2 selects the count source: 0 advances one tick per clock, 1 advances one tick only on clocks where aux_tick is high.
- R8: FLAGS bit 0 is set by the last tick of every period and FLAGS bit 1 by the completion of a burst; both drive irq outputs, stay set until a one is written to that bit of FLAGS (address 4), and a new event in the clearing cycle wins.
- R9: After reset the output and both flags are low and every register reads 0.
- R10: Registers are at addresses 0 CTRL (bit 0 enable, bit 1 burst mode, bit 2 clock select), 1 PERIOD, 2 DUTY, 3 BURST, 4 FLAGS, and read back through rd_addr/rd_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_tick | input | 1 | One-cycle strobe per auxiliary fast-clock tick, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 12 | Register read data (combinational) |
| pwm_out | output | 1 | Modulated output |
| irq_period | output | 1 | Sticky end-of-period flag |
| irq_stop | output | 1 | Sticky burst-complete flag |

## Verification
A register write applied before a rising edge changes the counter, the output and the readable state from that edge on. The output therefore follows a start or stop in the cycle right after the write. An end-of-period or burst-complete event becomes visible on its flag in the cycle after the edge that processed the terminal tick. Shadowed period and duty values appear only from the first tick of the next period. Read data is combinational and is checked a fraction of a cycle after the address is driven. The bench advances its behavioural model on each rising edge with the same input values the design sees. It compares the output and both flags against the model at every falling edge, so every result is compared in the cycle it is due.

// File: rtl/pwm12_pkg.sv
// Package: shared register addresses and control-bit positions for the
// burst-capable PWM. Assumes a 3-bit register address space.
package pwm12_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_PERIOD = 3'd1,
        ADR_DUTY   = 3'd2,
        ADR_BURST  = 3'd3,
        ADR_FLAGS  = 3'd4
    } pwm_addr_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_BURST_BIT = 1;
    localparam int CTRL_SEL_BIT   = 2;

    localparam int FLG_PERIOD_BIT = 0;
    localparam int FLG_STOP_BIT   = 1;

endpackage

// File: rtl/pwm12_regs.sv
// Module: register file of the PWM. It holds the control bits, the
// period/duty/burst shadow registers and the two sticky event flags.
// Assumes the bus width equals the counter width and is at least 3 bits.
module pwm12_regs
    import pwm12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             running,
    input  logic             ev_period,
    input  logic             ev_stop,
    output logic             start_req,
    output logic             stop_req,
    output logic             burst_mode,
    output logic             clk_sel,
    output logic [CNT_W-1:0] period_sh,
    output logic [CNT_W-1:0] duty_sh,
    output logic [CNT_W-1:0] burst_sh,
    output logic             flag_period,
    output logic             flag_stop
);

    logic ctrl_wr;
    logic flags_wr;

    // Decode control and flag-clear writes.
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADR_CTRL);
        flags_wr  = wr_en && (wr_addr == ADR_FLAGS);
        start_req = ctrl_wr && wr_data[CTRL_EN_BIT];
        stop_req  = ctrl_wr && !wr_data[CTRL_EN_BIT];
    end

    // Hold mode bits and shadow values written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_mode <= 1'b0;
            clk_sel    <= 1'b0;
            period_sh  <= '0;
            duty_sh    <= '0;
            burst_sh   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    burst_mode <= wr_data[CTRL_BURST_BIT];
                    clk_sel    <= wr_data[CTRL_SEL_BIT];
                end
                ADR_PERIOD: period_sh <= wr_data;
                ADR_DUTY:   duty_sh   <= wr_data;
                ADR_BURST:  burst_sh  <= wr_data;
                default: ;
            endcase
        end
    end

    // Sticky event flags: write-one-to-clear, a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_period <= 1'b0;
            flag_stop   <= 1'b0;
        end else begin
            flag_period <= (flag_period && !(flags_wr && wr_data[FLG_PERIOD_BIT])) || ev_period;
            flag_stop   <= (flag_stop   && !(flags_wr && wr_data[FLG_STOP_BIT]))   || ev_stop;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[CTRL_EN_BIT]    = running;
                rd_data[CTRL_BURST_BIT] = burst_mode;
                rd_data[CTRL_SEL_BIT]   = clk_sel;
            end
            ADR_PERIOD: rd_data = period_sh;
            ADR_DUTY:   rd_data = duty_sh;
            ADR_BURST:  rd_data = burst_sh;
            ADR_FLAGS: begin
                rd_data[FLG_PERIOD_BIT] = flag_period;
                rd_data[FLG_STOP_BIT]   = flag_stop;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm12_core.sv
// Module: period counter and run control. It loads the active period and
// duty from the shadows at start and at each wrap, counts bursts and stops
// itself. Assumes start/stop requests are single-cycle pulses.
module pwm12_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_tick,
    input  logic             clk_sel,
    input  logic             burst_mode,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] period_sh,
    input  logic [CNT_W-1:0] duty_sh,
    input  logic [CNT_W-1:0] burst_sh,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] duty_act,
    output logic             ev_period,
    output logic             ev_stop
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] left;
    logic             tick;
    logic             at_end;
    logic [CNT_W-1:0] per_load;
    logic [CNT_W-1:0] burst_load;

    // Pick the count source and detect the terminal tick of a period.
    always_comb begin
        tick       = clk_sel ? aux_tick : 1'b1;
        at_end     = (cnt == per_act - ONE);
        per_load   = (period_sh == '0) ? ONE : period_sh;
        burst_load = (burst_sh == '0) ? ONE : burst_sh;
        ev_period  = running && tick && at_end && !stop_req;
        ev_stop    = ev_period && burst_mode && (left == ONE);
    end

    // Run state, counter, active values and remaining burst periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt      <= '0;
            per_act  <= ONE;
            duty_act <= '0;
            left     <= ONE;
        end else if (stop_req) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start_req && !running) begin
            running  <= 1'b1;
            cnt      <= '0;
            per_act  <= per_load;
            duty_act <= duty_sh;
            left     <= burst_load;
        end else if (running && tick) begin
            if (at_end) begin
                cnt      <= '0;
                per_act  <= per_load;
                duty_act <= duty_sh;
                if (burst_mode) begin
                    if (left == ONE) begin
                        running <= 1'b0;
                    end else begin
                        left <= left - ONE;
                    end
                end
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/pwm12_cmp.sv
// Module: output comparator. It drives the output high while running and
// the counter is below the active duty. Assumes the counter never reaches
// the active period.
module pwm12_cmp #(
    parameter int CNT_W = 12
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_act,
    output logic             pwm_out
);

    // Compare the count against the duty for the current tick.
    always_comb begin
        pwm_out = running && (cnt < duty_act);
    end

endmodule

// File: rtl/pwm12_burst.sv
// Module: top of the burst-capable 12-bit PWM. It ties the register file,
// run control and comparator together. Assumes aux_tick is already
// synchronous to clk.
module pwm12_burst
    import pwm12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             irq_period,
    output logic             irq_stop
);

    logic             running;
    logic             ev_period;
    logic             ev_stop;
    logic             start_req;
    logic             stop_req;
    logic             burst_mode;
    logic             clk_sel;
    logic [CNT_W-1:0] period_sh;
    logic [CNT_W-1:0] duty_sh;
    logic [CNT_W-1:0] burst_sh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] duty_act;

    pwm12_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .running     (running),
        .ev_period   (ev_period),
        .ev_stop     (ev_stop),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .burst_mode  (burst_mode),
        .clk_sel     (clk_sel),
        .period_sh   (period_sh),
        .duty_sh     (duty_sh),
        .burst_sh    (burst_sh),
        .flag_period (irq_period),
        .flag_stop   (irq_stop)
    );

    pwm12_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .aux_tick   (aux_tick),
        .clk_sel    (clk_sel),
        .burst_mode (burst_mode),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .period_sh  (period_sh),
        .duty_sh    (duty_sh),
        .burst_sh   (burst_sh),
        .running    (running),
        .cnt        (cnt),
        .per_act    (per_act),
        .duty_act   (duty_act),
        .ev_period  (ev_period),
        .ev_stop    (ev_stop)
    );

    pwm12_cmp #(.CNT_W(CNT_W)) u_cmp (
        .running  (running),
        .cnt      (cnt),
        .duty_act (duty_act),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm12_burst_chk.sv
// Module: assertion checker bound to the PWM top. It watches run state,
// counter range, duty extremes, shadow timing and flag stickiness.
module pwm12_burst_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             running,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] duty_act,
    input logic             ev_stop,
    input logic             pwm_out,
    input logic             irq_stop
);

    AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pwm_out); // R4

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < per_act)); // R1

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_act == '0) |-> !pwm_out); // R6

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty_act >= per_act) |-> pwm_out); // R6

    AST_SHADOW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != '0) |-> ($stable(per_act) && $stable(duty_act))); // R5

    AST_BURST_SELF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !running); // R3

    AST_STOP_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stop && !(wr_en && wr_addr == 3'd4 && wr_data[1])) |=> irq_stop); // R8

endmodule

bind pwm12_burst pwm12_burst_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .running  (running),
    .cnt      (cnt),
    .per_act  (per_act),
    .duty_act (duty_act),
    .ev_stop  (ev_stop),
    .pwm_out  (pwm_out),
    .irq_stop (irq_stop)
);

// File: tb/pwm12_burst_tb.sv
`timescale 1ns/1ps
module pwm12_burst_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        pwm_out;
    logic        irq_period;
    logic        irq_stop;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_req = "R9";
    int aux_ctr = 0;

    // Behavioural reference state
    int m_run, m_cnt, m_per, m_duty, m_left, m_mode, m_sel;
    int m_psh, m_dsh, m_bsh, m_fp, m_fs;

    always #4 clk = ~clk;

    pwm12_burst u_dut (
        .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .irq_period(irq_period), .irq_stop(irq_stop)
    );

    // Auxiliary strobe: high on every third cycle.
    always @(negedge clk) begin
        aux_tick = (aux_ctr % 3 == 0);
        aux_ctr++;
    end

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_per = 1; m_duty = 0; m_left = 1;
            m_mode = 0; m_sel = 0; m_psh = 0; m_dsh = 0; m_bsh = 0;
            m_fp = 0; m_fs = 0;
        end else begin
            bit ctrl_w, tk, evp, evs;
            ctrl_w = wr_en && wr_addr == 0;
            tk = m_sel ? aux_tick : 1'b1;
            evp = 0; evs = 0;
            if (ctrl_w && !wr_data[0]) begin
                m_run = 0; m_cnt = 0;
            end else if (ctrl_w && wr_data[0] && !m_run) begin
                m_run = 1; m_cnt = 0;
                m_per = (m_psh == 0) ? 1 : m_psh;
                m_duty = m_dsh;
                m_left = (m_bsh == 0) ? 1 : m_bsh;
            end else if (m_run && tk) begin
                if (m_cnt == m_per - 1) begin
                    evp = 1; m_cnt = 0;
                    m_per = (m_psh == 0) ? 1 : m_psh;
                    m_duty = m_dsh;
                    if (m_mode) begin
                        if (m_left == 1) begin evs = 1; m_run = 0; end
                        else m_left--;
                    end
                end else m_cnt++;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_mode = wr_data[1]; m_sel = wr_data[2]; end
                    3'd1: m_psh = wr_data;
                    3'd2: m_dsh = wr_data;
                    3'd3: m_bsh = wr_data;
                    default: ;
                endcase
            end
            m_fp = ((m_fp != 0) && !(wr_en && wr_addr == 4 && wr_data[0])) || evp;
            m_fs = ((m_fs != 0) && !(wr_en && wr_addr == 4 && wr_data[1])) || evs;
        end
    end

    function automatic int model_rd(input int a);
        case (a)
            0: return m_run | (m_mode << 1) | (m_sel << 2);
            1: return m_psh;
            2: return m_dsh;
            3: return m_bsh;
            4: return m_fp | (m_fs << 1);
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison of the output and flags against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_pwm;
            exp_pwm = (m_run != 0) && (m_cnt < m_duty);
            n_tests++;
            if (pwm_out !== exp_pwm || irq_period !== m_fp[0] || irq_stop !== m_fs[0]) begin
                n_fail++;
                $display("FAIL %s pwm/irqp/irqs got %0b%0b%0b exp %0b%0b%0b", cur_req,
                         pwm_out, irq_period, irq_stop, exp_pwm, m_fp[0], m_fs[0]);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input string req);
        int e;
        @(negedge clk);
        rd_addr = a;
        #1;
        e = model_rd(a);
        n_tests++;
        if (rd_data !== e[11:0]) begin
            n_fail++;
            $display("FAIL %s rd[%0d] got %0h exp %0h", req, a, rd_data, e[11:0]);
        end
    endtask

    task automatic rd_exp(input logic [2:0] a, input int e, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        n_tests++;
        if (rd_data !== e[11:0]) begin
            n_fail++;
            $display("FAIL %s rd[%0d] got %0h exp %0h", req, a, rd_data, e[11:0]);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        cur_req = "R9";
        for (int a = 0; a < 5; a++) rd_exp(a[2:0], 0, "R9");
        n_tests++;
        if (pwm_out !== 1'b0 || irq_period !== 1'b0 || irq_stop !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 outputs got %0b%0b%0b exp 000", pwm_out, irq_period, irq_stop);
        end
        // R10: register readback
        cur_req = "R10";
        wr(3'd1, 12'd10); wr(3'd2, 12'd3); wr(3'd3, 12'd2);
        rd_exp(3'd1, 10, "R10"); rd_exp(3'd2, 3, "R10"); rd_exp(3'd3, 2, "R10");
        // R1/R2: continuous run, period 10 duty 3
        cur_req = "R2";
        wr(3'd0, 12'h001);
        idle(45);
        rd_exp(3'd0, 1, "R1");
        // R5: new shadows take effect at the wrap
        cur_req = "R5";
        wr(3'd1, 12'd6); wr(3'd2, 12'd2);
        idle(40);
        // R8: clear period flag, then it reasserts
        cur_req = "R8";
        wr(3'd4, 12'h001);
        idle(10);
        rd_exp(3'd4, 1, "R8");
        // R4: stop by writing enable 0
        cur_req = "R4";
        wr(3'd0, 12'h000);
        idle(10);
        rd_exp(3'd0, 0, "R4");
        // R6: zero duty and full duty
        cur_req = "R6";
        wr(3'd1, 12'd5); wr(3'd2, 12'd0);
        wr(3'd0, 12'h001);
        idle(20);
        wr(3'd2, 12'd7);
        idle(20);
        wr(3'd0, 12'h000);
        // R1: period 0 behaves as 1
        cur_req = "R1";
        wr(3'd1, 12'd0); wr(3'd2, 12'd1);
        wr(3'd0, 12'h001);
        idle(12);
        wr(3'd0, 12'h000);
        wr(3'd4, 12'h003);
        rd_exp(3'd4, 0, "R8");
        // R3: burst of 3 periods of 4, duty 1
        cur_req = "R3";
        wr(3'd1, 12'd4); wr(3'd2, 12'd1); wr(3'd3, 12'd3);
        wr(3'd0, 12'h003);
        idle(30);
        rd_exp(3'd0, 2, "R3");
        rd_exp(3'd4, 3, "R8");
        n_tests++;
        if (pwm_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R3 pwm after burst got %0b exp 0", pwm_out);
        end
        wr(3'd4, 12'h002);
        rd_exp(3'd4, 1, "R8");
        // R3: burst count 0 behaves as 1
        wr(3'd3, 12'd0);
        wr(3'd0, 12'h003);
        idle(10);
        rd_exp(3'd0, 2, "R3");
        // R7: auxiliary strobe as count source, continuous
        cur_req = "R7";
        wr(3'd1, 12'd5); wr(3'd2, 12'd2);
        wr(3'd0, 12'h005);
        idle(60);
        rd_chk(3'd0, "R7");
        wr(3'd0, 12'h000);
        // R7 with burst mode on the auxiliary strobe
        wr(3'd3, 12'd2);
        wr(3'd0, 12'h007);
        idle(50);
        rd_exp(3'd0, 6, "R7");
        idle(5);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule